// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by walking a two-level translation structure held in ordinary memory. A requester presents a virtual address and an access kind (read, write or execute). The walker reads a first-level entry from a directory whose base comes from a root-pointer input. That entry gives the base of a second-level table, and the walker then reads the leaf entry from that table.

If either entry is absent, or if the leaf forbids the access kind, the walker reports a fault code instead of an address. On success it returns the leaf's frame number joined to the untranslated 12-bit page offset, together with the leaf's uncached flag. When a read or write changes the leaf's referenced or modified flags, the walker writes the updated leaf back to its table slot before it responds. It serves one request at a time.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy, rsp_valid and mem_req_valid are 0, and req_ready is 1.
- R2: The first memory read is at byte address {root_base[31:12], vaddr[31:22], 2'b00}.
- R3: If the directory entry has bit 0 set, the second read is at {dir_entry[31:12], vaddr[21:12], 2'b00}.
- R4: A directory entry or a leaf entry with bit 0 clear ends the walk with rsp_fault = 1 (absent) and rsp_paddr = 0. An absent directory entry means no second read is made, and no absent walk writes memory.
- R5: A present leaf whose permission bit for the access kind is clear gives rsp_fault = 2 (protection) and writes nothing. Read uses bit 1, write uses bit 2 and execute uses bit 3. The access code is 0 for read, 1 for write and 2 for execute. Code 3 always faults. An absent leaf reports 1, never 2.
- R6: On success rsp_fault = 0, rsp_paddr = {leaf[31:12], vaddr[11:0]}, and rsp_nocache = leaf bit 6.
- R7: A successful read sets the referenced bit (leaf bit 4). A successful write sets both bit 4 and the modified bit (bit 5). The updated entry, with every other bit unchanged, goes back through exactly one write to the leaf's address.
- R8: A successful execute, or a read or write whose bits are already set, makes no memory write.
- R9: busy is 1 and req_ready is 0 from the cycle after a request is accepted until the response. rsp_valid lasts exactly one cycle, and after it the walker is idle again.
- R10: A memory request stays asserted, with a stable address, until mem_req_ready. Every address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 32 | Directory base; bits 31:12 are used, sampled when a request is accepted |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_write | output | 1 | 1 for the leaf write-back, 0 for reads |
| mem_req_wdata | output | 32 | Updated leaf entry |
| mem_rsp_valid | input | 1 | Read data valid, one cycle, later than acceptance |
| mem_rsp_data | input | 32 | Read data word |
| rsp_valid | output | 1 | Translation result valid for one cycle |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 absent, 2 protection |
| rsp_nocache | output | 1 | Leaf uncached flag, 0 on a fault |

## Verification
A result appears one cycle after its final memory event. That event is the directory or leaf read response for a fault or a walk with no update, and the write handshake for a walk that updates the leaf. The bench never assumes a fixed latency, because the memory model stalls the request side at random and answers after 1 to 3 cycles. Instead it polls rsp_valid on falling edges and compares all result ports in that one cycle. It checks busy and req_ready on the first falling edge after acceptance. The memory model logs every read address and write in order, and the bench compares that log and the final memory contents against a model computed from the table contents before the request.

// File: rtl/pt_walk_pkg.sv
`timescale 1ns/1ps
package pt_walk_pkg;

    localparam int ADDR_W   = 32;
    localparam int OFF_W    = 12;
    localparam int TIDX_W   = 10;
    localparam int DIDX_W   = ADDR_W - OFF_W - TIDX_W;
    localparam int FRAME_W  = ADDR_W - OFF_W;
    localparam int SPARE_W  = OFF_W - 7;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PERM   = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_FETCH_DIR,
        WS_FETCH_LEAF,
        WS_UPDATE,
        WS_DONE
    } walk_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [SPARE_W-1:0] spare;
        logic               nocache;
        logic               modified;
        logic               referenced;
        logic               can_x;
        logic               can_w;
        logic               can_r;
        logic               present;
    } tbl_entry_t;

    typedef struct packed {
        logic [DIDX_W-1:0] dir_idx;
        logic [TIDX_W-1:0] tbl_idx;
        logic [OFF_W-1:0]  offset;
    } vaddr_t;

    function automatic logic access_allowed(tbl_entry_t e, access_e a);
        case (a)
            ACC_READ:  return e.can_r;
            ACC_WRITE: return e.can_w;
            ACC_EXEC:  return e.can_x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pt_index_gen.sv
`timescale 1ns/1ps
module pt_index_gen
    import pt_walk_pkg::*;
(
    input  logic                use_leaf,
    input  logic [ADDR_W-1:0]   root_ptr,
    input  logic [FRAME_W-1:0]  table_frame,
    input  vaddr_t              va,
    output logic [ADDR_W-1:0]   word_addr
);
    localparam int SLOT_W = 2;

    logic [ADDR_W-1:0] dir_slot;
    logic [ADDR_W-1:0] leaf_slot;

    always_comb begin
        dir_slot  = {root_ptr[ADDR_W-1:OFF_W], va.dir_idx, {SLOT_W{1'b0}}};
        leaf_slot = {table_frame, va.tbl_idx, {SLOT_W{1'b0}}};
        word_addr = use_leaf ? leaf_slot : dir_slot;
    end
endmodule

// File: rtl/pt_entry_check.sv
`timescale 1ns/1ps
module pt_entry_check
    import pt_walk_pkg::*;
(
    input  tbl_entry_t entry,
    input  access_e    access,
    output fault_e     fault,
    output tbl_entry_t updated,
    output logic       needs_wb
);
    always_comb begin
        updated = entry;
        if (!entry.present) begin
            fault = FLT_ABSENT;
        end else if (!access_allowed(entry, access)) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_NONE;
        end
        if (fault == FLT_NONE && (access == ACC_READ || access == ACC_WRITE)) begin
            updated.referenced = 1'b1;
        end
        if (fault == FLT_NONE && access == ACC_WRITE) begin
            updated.modified = 1'b1;
        end
        needs_wb = (updated != entry);
    end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
    import pt_walk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] root_base,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_access,
    output logic        busy,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    output logic        mem_req_write,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic [1:0]  rsp_fault,
    output logic        rsp_nocache
);
    walk_state_e        state;
    vaddr_t             va_q;
    access_e            acc_q;
    logic [ADDR_W-1:0]  root_q;
    logic               issued_q;
    logic [FRAME_W-1:0] tbl_frame_q;
    tbl_entry_t         wb_q;
    logic [ADDR_W-1:0]  paddr_q;
    fault_e             fault_q;
    logic               nocache_q;

    tbl_entry_t rsp_entry;
    fault_e     chk_fault;
    tbl_entry_t chk_updated;
    logic       chk_wb;
    logic       rsp_here;

    assign rsp_entry = tbl_entry_t'(mem_rsp_data);
    assign rsp_here  = issued_q && mem_rsp_valid;

    pt_index_gen u_index (
        .use_leaf    (state != WS_FETCH_DIR),
        .root_ptr    (root_q),
        .table_frame (tbl_frame_q),
        .va          (va_q),
        .word_addr   (mem_req_addr)
    );

    pt_entry_check u_check (
        .entry    (rsp_entry),
        .access   (acc_q),
        .fault    (chk_fault),
        .updated  (chk_updated),
        .needs_wb (chk_wb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= WS_IDLE;
            va_q        <= '0;
            acc_q       <= ACC_READ;
            root_q      <= '0;
            issued_q    <= 1'b0;
            tbl_frame_q <= '0;
            wb_q        <= '0;
            paddr_q     <= '0;
            fault_q     <= FLT_NONE;
            nocache_q   <= 1'b0;
        end else begin
            case (state)
                WS_IDLE: begin
                    if (req_valid) begin
                        va_q      <= vaddr_t'(req_vaddr);
                        acc_q     <= access_e'(req_access);
                        root_q    <= root_base;
                        issued_q  <= 1'b0;
                        fault_q   <= FLT_NONE;
                        paddr_q   <= '0;
                        nocache_q <= 1'b0;
                        state     <= WS_FETCH_DIR;
                    end
                end
                WS_FETCH_DIR: begin
                    if (mem_req_valid && mem_req_ready) begin
                        issued_q <= 1'b1;
                    end
                    if (rsp_here) begin
                        issued_q <= 1'b0;
                        if (!rsp_entry.present) begin
                            fault_q <= FLT_ABSENT;
                            state   <= WS_DONE;
                        end else begin
                            tbl_frame_q <= rsp_entry.frame;
                            state       <= WS_FETCH_LEAF;
                        end
                    end
                end
                WS_FETCH_LEAF: begin
                    if (mem_req_valid && mem_req_ready) begin
                        issued_q <= 1'b1;
                    end
                    if (rsp_here) begin
                        issued_q <= 1'b0;
                        fault_q  <= chk_fault;
                        if (chk_fault != FLT_NONE) begin
                            state <= WS_DONE;
                        end else begin
                            paddr_q   <= {rsp_entry.frame, va_q.offset};
                            nocache_q <= rsp_entry.nocache;
                            wb_q      <= chk_updated;
                            state     <= chk_wb ? WS_UPDATE : WS_DONE;
                        end
                    end
                end
                WS_UPDATE: begin
                    if (mem_req_ready) begin
                        state <= WS_DONE;
                    end
                end
                default: begin
                    state <= WS_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        req_ready     = (state == WS_IDLE);
        busy          = (state != WS_IDLE);
        mem_req_valid = (((state == WS_FETCH_DIR) || (state == WS_FETCH_LEAF)) && !issued_q)
                        || (state == WS_UPDATE);
        mem_req_write = (state == WS_UPDATE);
        mem_req_wdata = wb_q;
        rsp_valid     = (state == WS_DONE);
        rsp_paddr     = paddr_q;
        rsp_fault     = fault_q;
        rsp_nocache   = nocache_q;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!busy && !rsp_valid && !mem_req_valid)); // R1
    AST_NO_LEAF_AFTER_ABSENT_DIR: assert property (@(posedge clk) disable iff (rst)
        (state == WS_FETCH_DIR && rsp_here && !rsp_entry.present) |=> (rsp_valid && rsp_fault == 2'd1)); // R4
    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == WS_FETCH_LEAF && rsp_here && chk_fault != FLT_NONE) |=> !mem_req_write); // R5
    AST_WB_MARKS_REF: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata[0] && mem_req_wdata[4])); // R7
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (busy && !req_ready)); // R9
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready)); // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00)); // R10
    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault != 2'd3)); // R5
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
    localparam logic [31:0] ROOT = 32'h0000_3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_req_write;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        rsp_nocache;

    pt_walker uut (
        .clk(clk), .rst(rst), .root_base(ROOT),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_access(req_access), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_write(mem_req_write),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_nocache(rsp_nocache)
    );

    always #2 clk = ~clk;

    logic [31:0] mem [0:4095];
    int          n_rd, n_wr;
    logic [31:0] rd_log [0:3];
    logic [31:0] wr_addr, wr_data;
    int          tests = 0, fails = 0;
    bit          finished = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: random stall on request, 1..3 cycle read latency
    initial begin
        forever begin
            @(negedge clk);
            mem_req_ready = ($urandom % 4) != 0;
            if (mem_req_valid && mem_req_ready && !rst) begin
                logic [31:0] a;
                logic        w;
                logic [31:0] d;
                a = mem_req_addr; w = mem_req_write; d = mem_req_wdata;
                @(posedge clk);
                if (w) begin
                    mem[a[13:2]] = d;
                    wr_addr = a; wr_data = d; n_wr++;
                end else begin
                    if (n_rd < 4) rd_log[n_rd] = a;
                    n_rd++;
                    @(negedge clk);
                    mem_req_ready = 1'b0;
                    repeat ($urandom % 3) @(negedge clk);
                    mem_rsp_data  = mem[a[13:2]];
                    mem_rsp_valid = 1'b1;
                    @(negedge clk);
                    mem_rsp_valid = 1'b0;
                end
            end
        end
    end

    task automatic walk(logic [31:0] va, logic [1:0] acc);
        logic [31:0] dent, leaf, leaf_addr, newleaf, exp_pa;
        logic [1:0]  exp_f;
        logic        ok_perm, exp_nc;
        int          exp_rd, exp_wr, guard;
        dent = mem[{ROOT[13:12], va[31:22]}];
        leaf_addr = {dent[31:12], va[21:12], 2'b00};
        leaf = mem[leaf_addr[13:2]];
        ok_perm = (acc == 2'd0) ? leaf[1] : (acc == 2'd1) ? leaf[2] : (acc == 2'd2) ? leaf[3] : 1'b0;
        newleaf = leaf;
        exp_pa = '0; exp_nc = 1'b0; exp_wr = 0;
        if (!dent[0]) begin
            exp_f = 2'd1; exp_rd = 1;
        end else begin
            exp_rd = 2;
            if (!leaf[0]) exp_f = 2'd1;
            else if (!ok_perm) exp_f = 2'd2;
            else begin
                exp_f = 2'd0;
                exp_pa = {leaf[31:12], va[11:0]};
                exp_nc = leaf[6];
                if (acc <= 2'd1) newleaf[4] = 1'b1;
                if (acc == 2'd1) newleaf[5] = 1'b1;
                exp_wr = (newleaf != leaf) ? 1 : 0;
            end
        end
        n_rd = 0; n_wr = 0;
        @(negedge clk);
        req_vaddr = va; req_access = acc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy after accept", {31'd0, busy}, 32'd1);
        chk("R9 req_ready low", {31'd0, req_ready}, 32'd0);
        guard = 0;
        while (!rsp_valid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk("R9 response arrives", {31'd0, rsp_valid}, 32'd1);
        chk("R2 directory read address", rd_log[0], {ROOT[31:12], va[31:22], 2'b00});
        if (exp_rd == 2) chk("R3 leaf read address", rd_log[1], leaf_addr);
        chk(exp_f == 2'd1 ? "R4 absent fault" : exp_f == 2'd2 ? "R5 protection fault" : "R6 fault code",
            {30'd0, rsp_fault}, {30'd0, exp_f});
        chk("R4 read count", n_rd, exp_rd);
        chk("R6 physical address", rsp_paddr, exp_pa);
        chk("R6 uncached flag", {31'd0, rsp_nocache}, {31'd0, exp_nc});
        chk(exp_wr != 0 ? "R7 write count" : "R8 no write", n_wr, exp_wr);
        if (exp_wr != 0) begin
            chk("R7 write address", wr_addr, leaf_addr);
            chk("R7 written entry", wr_data, newleaf);
        end
        chk("R7 memory leaf", mem[leaf_addr[13:2]], newleaf);
        @(negedge clk);
        chk("R9 idle after response", {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    function automatic logic [31:0] dir_slot(logic [9:0] i);
        return {20'd0, ROOT[13:12], i} ;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3072; i++) mem[i] = $urandom;
        for (int i = 0; i < 1024; i++)
            mem[3072 + i] = {20'(i % 3), 11'd0, (($urandom % 8) != 0)};
        repeat (3) @(negedge clk);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
        chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
        rst = 1'b0;

        // directed: absent directory entry
        mem[dir_slot(10'd5)] = 32'h0000_1000;
        walk({10'd5, 10'd7, 12'h123}, 2'd0);
        // absent leaf
        mem[dir_slot(10'd6)] = 32'h0000_1001;
        mem[1024 + 9] = 32'hABCD_E07E;
        walk({10'd6, 10'd9, 12'h456}, 2'd1);
        // protection per access kind, and reserved code
        mem[1024 + 10] = 32'h1234_5003;
        walk({10'd6, 10'd10, 12'hFFF}, 2'd1);
        walk({10'd6, 10'd10, 12'h000}, 2'd2);
        walk({10'd6, 10'd10, 12'h001}, 2'd0);
        mem[1024 + 11] = 32'h5555_500F;
        walk({10'd6, 10'd11, 12'h002}, 2'd3);
        // write sets both bits, uncached flag passed, then no rewrite
        mem[1024 + 12] = 32'h0F0F_0047;
        walk({10'd6, 10'd12, 12'hABC}, 2'd1);
        walk({10'd6, 10'd12, 12'hABD}, 2'd1);
        // execute never writes
        mem[1024 + 13] = 32'h7777_7009;
        walk({10'd6, 10'd13, 12'h010}, 2'd2);

        // random walks
        for (int k = 0; k < 300; k++) begin
            logic [31:0] va;
            logic [31:0] pa;
            va = $urandom;
            pa = mem[{20'd0, ROOT[13:12], va[31:22]}];
            if (pa[0]) begin
                logic [31:0] la;
                la = {pa[31:12], va[21:12], 2'b00};
                if (($urandom % 4) == 0) mem[la[13:2]][0] = 1'b0;
                else if (($urandom % 2) == 0) mem[la[13:2]][0] = 1'b1;
            end
            walk(va, 2'($urandom % 4));
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule